// File: doc/BRIEF.md
# Mirrored-Operand Barrel Shifter

This block shifts a data word left logically, right logically or right arithmetically, and all three use one right-shifting core. A left shift mirrors the operand, so bit 0 swaps with the top bit, before it enters the core. The core's output is then mirrored back. Right shifts pass through the core unchanged. For an arithmetic shift the core fills from the top with the operand's sign bit. For the other kinds it fills with zero.

A build-time parameter decides where the output mirroring sits. With early injection set, the whole path is combinational and the result appears in the cycle the inputs are presented. With it clear, the core output is registered along with the shift kind and the valid flag, and the mirroring happens after that register. The result then appears one clock later, and a stall input freezes the register.

Top module: `rev_barrel_shifter`

## Requirements
- R1: Kind code 2'b00 gives a logical left shift: the result is the operand shifted toward the MSB, with zeros entering at bit 0.
- R2: Kind code 2'b01 gives a logical right shift, with zeros entering at the MSB.
- R3: Kind code 2'b10 gives an arithmetic right shift, with copies of operand bit DATA_W-1 entering at the MSB.
- R4: Kind code 2'b11 behaves exactly like code 2'b01.
- R5: Only the low log2(DATA_W) bits of `amt_src` set the shift distance. The remaining bits do not affect the result.
- R6: A shift distance of zero returns the operand unchanged for every kind code.
- R7: With EARLY_INJECT=1, `res` and `res_valid` reflect the current inputs in the same cycle.
- R8: With EARLY_INJECT=0, `res` and `res_valid` show the result of the inputs sampled at the previous rising clock edge on which `stall` was low.
- R9: With EARLY_INJECT=0, a clock edge with `stall` high leaves `res` and `res_valid` unchanged.
- R10: With EARLY_INJECT=0, an active-low reset clears `res_valid` and makes `res` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only by the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the request |
| stall | input | 1 | Holds the stage register when high |
| operand | input | DATA_W | Word to shift |
| amt_src | input | DATA_W | Shift distance source; low bits used |
| kind | input | 2 | 00 left, 01 right logical, 10 right arithmetic, 11 as 01 |
| res_valid | output | 1 | Qualifies `res` |
| res | output | DATA_W | Shifted word |

## Verification
The combinational instance has zero latency. Its outputs are compared one time unit after the inputs change on the falling edge, well before the next rising edge. The registered instance has one cycle of latency. The bench keeps a model of that stage register that loads only on edges where stall is low, and it compares against that model one time unit after the rising edge. Stalled edges are therefore checked to hold the previous value, not the new request.

// File: rtl/shf_pkg.sv
package shf_pkg;

   typedef enum logic [1:0] {
      SHK_LSL = 2'b00,
      SHK_LSR = 2'b01,
      SHK_ASR = 2'b10,
      SHK_ALT = 2'b11
   } shift_kind_e;

   function automatic logic kind_is_left(input shift_kind_e k);
      return (k == SHK_LSL);
   endfunction

   function automatic logic kind_is_arith(input shift_kind_e k);
      return (k == SHK_ASR);
   endfunction

endpackage

// File: rtl/shf_mirror.sv
module shf_mirror #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/shf_prep.sv
module shf_prep
   import shf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] operand,
   input  shift_kind_e       kind,
   output logic [DATA_W-1:0] core_in,
   output logic              fill
);
   logic [DATA_W-1:0] mirrored;

   shf_mirror #(.W(DATA_W)) u_mirror (
      .din  (operand),
      .dout (mirrored)
   );

   always_comb begin
      core_in = kind_is_left(kind) ? mirrored : operand;
      fill    = kind_is_arith(kind) & operand[DATA_W-1];
   end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic              fill,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] lvl [0:AMT_W];

   assign lvl[0] = din;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int SH = 1 << k;
      logic [DATA_W-1:0] moved;
      assign moved      = {{SH{fill}}, lvl[k][DATA_W-1:SH]};
      assign lvl[k+1]   = amt[k] ? moved : lvl[k];
   end

   assign dout = lvl[AMT_W];
endmodule

// File: rtl/shf_finish.sv
module shf_finish #(
   parameter int DATA_W       = 32,
   parameter bit EARLY_INJECT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic [DATA_W-1:0] mid,
   input  logic              left,
   input  logic              vld,
   output logic [DATA_W-1:0] res,
   output logic              res_valid
);
   logic [DATA_W-1:0] mid_q;
   logic              left_q;
   logic              vld_q;
   logic [DATA_W-1:0] mid_mirror;

   if (EARLY_INJECT) begin : g_comb
      assign mid_q  = mid;
      assign left_q = left;
      assign vld_q  = vld;
      logic unused_seq;
      assign unused_seq = clk ^ rst_n ^ stall;
   end else begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mid_q  <= '0;
            left_q <= 1'b0;
            vld_q  <= 1'b0;
         end else if (!stall) begin
            mid_q  <= mid;
            left_q <= left;
            vld_q  <= vld;
         end
      end
   end

   shf_mirror #(.W(DATA_W)) u_mirror (
      .din  (mid_q),
      .dout (mid_mirror)
   );

   assign res       = left_q ? mid_mirror : mid_q;
   assign res_valid = vld_q;
endmodule

// File: rtl/rev_barrel_shifter.sv
module rev_barrel_shifter
   import shf_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter bit EARLY_INJECT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              stall,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] amt_src,
   input  logic [1:0]        kind,
   output logic              res_valid,
   output logic [DATA_W-1:0] res
);
   localparam int AMT_W = $clog2(DATA_W);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("rev_barrel_shifter: DATA_W must be a power of two of at least 2");
   end

   shift_kind_e       kind_e;
   logic [DATA_W-1:0] core_in;
   logic [DATA_W-1:0] core_out;
   logic              fill;
   logic [AMT_W-1:0]  amt;
   logic              unused_amt_hi;

   assign kind_e        = shift_kind_e'(kind);
   assign amt           = amt_src[AMT_W-1:0];
   assign unused_amt_hi = ^amt_src[DATA_W-1:AMT_W];

   shf_prep #(.DATA_W(DATA_W)) u_prep (
      .operand (operand),
      .kind    (kind_e),
      .core_in (core_in),
      .fill    (fill)
   );

   shf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
      .din  (core_in),
      .fill (fill),
      .amt  (amt),
      .dout (core_out)
   );

   shf_finish #(.DATA_W(DATA_W), .EARLY_INJECT(EARLY_INJECT)) u_finish (
      .clk       (clk),
      .rst_n     (rst_n),
      .stall     (stall),
      .mid       (core_out),
      .left      (kind_is_left(kind_e)),
      .vld       (in_valid),
      .res       (res),
      .res_valid (res_valid)
   );
endmodule

// File: rtl/shf_checker.sv
module shf_checker #(
   parameter int DATA_W       = 32,
   parameter bit EARLY_INJECT = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              stall,
   input logic [DATA_W-1:0] operand,
   input logic [DATA_W-1:0] amt_src,
   input logic [1:0]        kind,
   input logic              res_valid,
   input logic [DATA_W-1:0] res
);
   localparam int AMT_W = $clog2(DATA_W);
   logic amt_zero;
   assign amt_zero = (amt_src[AMT_W-1:0] == '0);

   if (EARLY_INJECT) begin : g_comb_chk
      // R7
      comb_valid_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid == in_valid);
      // R6
      comb_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         amt_zero |-> res == operand);
      // R2
      comb_lsr_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (kind == 2'b01 && !amt_zero) |-> !res[DATA_W-1]);
      // R3
      comb_asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (kind == 2'b10) |-> res[DATA_W-1] == operand[DATA_W-1]);
   end else begin : g_reg_chk
      // R8
      pipe_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !stall |=> res_valid == $past(in_valid));
      // R9
      pipe_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stall |=> ($stable(res) && $stable(res_valid)));
      // R6
      pipe_zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!stall && amt_zero) |=> res == $past(operand));
      // R3
      pipe_asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!stall && kind == 2'b10) |=> res[DATA_W-1] == $past(operand[DATA_W-1]));
      // R10
      pipe_reset_clear_chk: assert property (@(posedge clk)
         !rst_n |=> !res_valid);
   end
endmodule

bind rev_barrel_shifter shf_checker #(
   .DATA_W       (DATA_W),
   .EARLY_INJECT (EARLY_INJECT)
) u_shf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .stall     (stall),
   .operand   (operand),
   .amt_src   (amt_src),
   .kind      (kind),
   .res_valid (res_valid),
   .res       (res)
);

// File: tb/rev_barrel_shifter_bench.sv
`timescale 1ns/1ps
module rev_barrel_shifter_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         stall = 1'b0;
   logic [W-1:0] operand = '0;
   logic [W-1:0] amt_src = '0;
   logic [1:0]   kind = 2'b00;

   logic         p_valid, c_valid;
   logic [W-1:0] p_res, c_res;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_res = '0;
   logic         m_valid = 1'b0;

   always #2 clk = ~clk;

   rev_barrel_shifter #(.DATA_W(W), .EARLY_INJECT(1'b0)) u_rev_barrel_shifter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stall(stall),
      .operand(operand), .amt_src(amt_src), .kind(kind),
      .res_valid(p_valid), .res(p_res));

   rev_barrel_shifter #(.DATA_W(W), .EARLY_INJECT(1'b1)) u_rev_barrel_shifter_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .stall(stall),
      .operand(operand), .amt_src(amt_src), .kind(kind),
      .res_valid(c_valid), .res(c_res));

   function automatic logic [W-1:0] expect_shift(input logic [W-1:0] op,
                                                 input logic [W-1:0] a,
                                                 input logic [1:0] k);
      int n;
      n = int'(a[4:0]);
      case (k)
         2'b00:   return op << n;
         2'b10:   return W'($signed(op) >>> n);
         default: return op >> n;
      endcase
   endfunction

   function automatic string tag_for(input logic [W-1:0] a, input logic [1:0] k);
      if (a[4:0] == 5'd0) return "R6";
      case (k)
         2'b00:   return "R1";
         2'b01:   return "R2";
         2'b10:   return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] op, input logic [W-1:0] a,
                        input logic [1:0] k, input logic v, input logic st,
                        input string tag);
      logic [W-1:0] e;
      e = expect_shift(op, a, k);
      @(negedge clk);
      operand = op; amt_src = a; kind = k; in_valid = v; stall = st;
      #1;
      check(tag, c_res, e);                       // R7 same-cycle result
      check("R7", W'(c_valid), W'(v));
      @(posedge clk);
      if (!st) begin m_res = e; m_valid = v; end
      #1;
      check(st ? "R9" : "R8", p_res, m_res);
      check(st ? "R9" : "R8", W'(p_valid), W'(m_valid));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seed_init;
      seed_init = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      check("R10", W'(p_valid), '0);
      check("R10", p_res, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      apply(32'h8000_0001, 32'd1,  2'b00, 1'b1, 1'b0, "R1");
      apply(32'h8000_0001, 32'd31, 2'b00, 1'b1, 1'b0, "R1");
      apply(32'h8000_0000, 32'd31, 2'b01, 1'b1, 1'b0, "R2");
      apply(32'h8000_0000, 32'd31, 2'b10, 1'b1, 1'b0, "R3");
      apply(32'h7FFF_FFFF, 32'd4,  2'b10, 1'b1, 1'b0, "R3");
      apply(32'hF0F0_1234, 32'd8,  2'b11, 1'b1, 1'b0, "R4");
      apply(32'hF0F0_1234, 32'hFFFF_FFE8, 2'b10, 1'b1, 1'b0, "R5");
      apply(32'h1234_5678, 32'hABCD_EF00, 2'b00, 1'b1, 1'b0, "R6");
      apply(32'hDEAD_BEEF, 32'd0,  2'b10, 1'b1, 1'b0, "R6");
      apply(32'hDEAD_BEEF, 32'd0,  2'b01, 1'b0, 1'b0, "R6");
      // R9 stall holds the previous result
      apply(32'h0000_00FF, 32'd4,  2'b00, 1'b1, 1'b0, "R1");
      apply(32'hFFFF_0000, 32'd12, 2'b10, 1'b0, 1'b1, "R3");
      apply(32'h1111_1111, 32'd3,  2'b01, 1'b1, 1'b1, "R2");
      apply(32'h1111_1111, 32'd3,  2'b01, 1'b1, 1'b0, "R2");

      // random traffic
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] op, a;
         logic [1:0]   k;
         logic         v, st;
         op = $urandom(); a = $urandom(); k = 2'($urandom());
         v  = 1'($urandom()); st = ($urandom_range(0, 3) == 0);
         apply(op, a, k, v, st, tag_for(a, k));
      end

      // R10 reset mid-stream
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10", W'(p_valid), '0);
      check("R10", p_res, '0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule